// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Bridge for a Split Display

This block sits between an 8-bit microcontroller bus and a display controller whose frame memory is split into a left half and a right half. One set of bus pins carries either of two classic parallel protocols. In the enable-strobe protocol, one pin is an active-high enable and a second pin picks the direction. In the separate-strobe protocol, those same two pins are active-low read and write strobes. Two strap inputs choose the protocol, or switch the parallel bus off altogether.

All bus pins are resynchronised into a single system clock. The block finds the commit edge of each write and turns it into a one-cycle write pulse for the left half, the right half, or both. Each pulse comes with the written byte and its data/instruction flag. While a read is in progress, the block raises read enables and drives the bidirectional data bus with the byte from the addressed half. At all other times the data bus is left floating. Each half is reached through its own pair of chip selects: one active high and one active low.

Top module: `duo_host_bus`

## Requirements
- R1: While `rstN` is low, and after it is released with the bus idle, every write pulse, read enable, `wrData`, `wrIsData` and `rdIsData` is 0, and `dataBus` is high impedance.
- R2: With `strapPar`=1 and `strapMode`=1 (enable-strobe protocol), a falling edge of `busE` while `busRw`=0 produces exactly one single-cycle write pulse to each selected half, with `wrData` equal to the byte on `dataBus` and `wrIsData` equal to `busRs`.
- R3: In the enable-strobe protocol, while `busE`=1 and `busRw`=1, each selected half has its read enable high, `rdIsData` equals `busRs`, and `dataBus` carries the selected half's read byte.
- R4: With `strapPar`=1 and `strapMode`=0 (separate-strobe protocol), a rising edge of `busRw` (the active-low write strobe) while `busE`=1 produces exactly one single-cycle write pulse to each selected half, carrying the byte and the `busRs` flag.
- R5: In the separate-strobe protocol, while `busE`=0 (the active-low read strobe), each selected half has its read enable high and `dataBus` carries the selected half's read byte.
- R6: The left half is selected only when `csLeftHi`=1 and `csLeftLoN`=0. The right half is selected only when `csRightHi`=1 and `csRightLoN`=0. Any other chip-select combination causes no write pulse and no read enable for that half.
- R7: When both halves are selected, a write pulses both halves with the same byte, and a read drives `dataBus` with the left half's byte.
- R8: With `strapPar`=0, bus activity produces no write pulse and no read enable, and `dataBus` stays high impedance.
- R9: `dataBus` is driven only while a read is active and at least one half is selected. Otherwise it is high impedance.
- R10: A write pulse lasts one clock cycle, and `wrData` changes only on the cycle a write pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapPar | input | 1 | 1 enables the parallel bus |
| strapMode | input | 1 | 1 selects the enable-strobe protocol, 0 the separate-strobe protocol |
| busE | input | 1 | Enable (active high) or read strobe (active low) |
| busRw | input | 1 | Direction (1 = read) or write strobe (active low) |
| busRs | input | 1 | 1 = memory data, 0 = instruction |
| csLeftHi | input | 1 | Left-half select, active high |
| csLeftLoN | input | 1 | Left-half select, active low |
| csRightHi | input | 1 | Right-half select, active high |
| csRightLoN | input | 1 | Right-half select, active low |
| dataBus | inout | 8 | Bidirectional host data bus |
| leftRdData | input | 8 | Read byte from the left half |
| rightRdData | input | 8 | Read byte from the right half |
| leftWrPulse | output | 1 | One-cycle write pulse to the left half |
| rightWrPulse | output | 1 | One-cycle write pulse to the right half |
| wrData | output | 8 | Byte of the latest write |
| wrIsData | output | 1 | Data/instruction flag of the latest write |
| leftRdEn | output | 1 | Read in progress on the left half |
| rightRdEn | output | 1 | Read in progress on the right half |
| rdIsData | output | 1 | Data/instruction flag of the current read |

## Verification
A wrong edge detector or a stale strobe history shows up at the ports as a missing, doubled or misrouted write pulse. Such a fault is visible within about three clocks of the strobe edge and is caught by counting pulses per half over each access. A wrong chip-select decode or a wrong protocol decode shows up as a read enable on the wrong half, or as a bus that is driven when it should float (or floats when it should be driven). The sweep over every chip-select combination, in both protocols and with the bus switched off, reveals these a few cycles after the read strobe changes.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  localparam int DATA_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic wrLeft;
    logic wrRight;
    logic rdLeft;
    logic rdRight;
    logic isData;
  } hbbStrobe_t;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/hbb_ctrl.sv
module hbb_ctrl
  import hbb_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapPar,
  input  logic       strapMode,
  input  logic       busE,
  input  logic       busRw,
  input  logic       busRs,
  input  logic       csLeftHi,
  input  logic       csLeftLoN,
  input  logic       csRightHi,
  input  logic       csRightLoN,
  output hbbStrobe_t strb
);
  localparam int CTL_W = 7;

  logic [CTL_W-1:0] ctlRaw, ctlS;
  logic eS, rwS, rsS, cs1S, cs2nS, cs3S, cs4nS;
  logic ePrev, rwPrev;
  logic selLeft, selRight, rdActive, commit, is6800;

  assign ctlRaw = {busE, busRw, busRs, csLeftHi, csLeftLoN, csRightHi, csRightLoN};

  // strobes idle inactive: RW and the active-low selects reset high
  hbb_sync #(.W(CTL_W), .STAGES(STAGES), .RST_VAL(7'b0100101)) ctlSync_i (
    .clk(clk), .rstN(rstN), .din(ctlRaw), .dout(ctlS)
  );

  assign {eS, rwS, rsS, cs1S, cs2nS, cs3S, cs4nS} = ctlS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ePrev  <= 1'b0;
      rwPrev <= 1'b1;
    end else begin
      ePrev  <= eS;
      rwPrev <= rwS;
    end
  end

  assign is6800   = strapMode;
  assign selLeft  = cs1S & ~cs2nS;
  assign selRight = cs3S & ~cs4nS;

  always_comb begin
    if (is6800) begin
      rdActive = eS & rwS;
      commit   = ePrev & ~eS & ~rwS;
    end else begin
      rdActive = ~eS;
      commit   = ~rwPrev & rwS & eS;
    end
    rdActive = rdActive & strapPar;
    commit   = commit & strapPar;
  end

  always_comb begin
    strb.wrLeft  = commit & selLeft;
    strb.wrRight = commit & selRight;
    strb.rdLeft  = rdActive & selLeft;
    strb.rdRight = rdActive & selRight;
    strb.isData  = rsS;
  end

  // R8
  par_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strapPar |-> !(strb.wrLeft | strb.wrRight | strb.rdLeft | strb.rdRight));

  // R2
  no_rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((strb.wrLeft | strb.wrRight) & (strb.rdLeft | strb.rdRight)));

  // R10
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLeft | strb.wrRight) |=> !(strb.wrLeft | strb.wrRight));
endmodule

// File: rtl/hbb_datapath.sv
module hbb_datapath
  import hbb_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  hbbStrobe_t   strb,
  input  logic [W-1:0] busIn,
  input  logic [W-1:0] leftRdData,
  input  logic [W-1:0] rightRdData,
  output logic         busDrive,
  output logic [W-1:0] busOut,
  output logic         leftWrPulse,
  output logic         rightWrPulse,
  output logic [W-1:0] wrData,
  output logic         wrIsData,
  output logic         leftRdEn,
  output logic         rightRdEn,
  output logic         rdIsData
);
  logic [W-1:0] dataS;

  hbb_sync #(.W(W), .STAGES(STAGES), .RST_VAL('0)) dataSync_i (
    .clk(clk), .rstN(rstN), .din(busIn), .dout(dataS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftWrPulse  <= 1'b0;
      rightWrPulse <= 1'b0;
      wrData       <= '0;
      wrIsData     <= 1'b0;
    end else begin
      leftWrPulse  <= strb.wrLeft;
      rightWrPulse <= strb.wrRight;
      if (strb.wrLeft | strb.wrRight) begin
        wrData   <= dataS;
        wrIsData <= strb.isData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftRdEn  <= 1'b0;
      rightRdEn <= 1'b0;
      rdIsData  <= 1'b0;
      busDrive  <= 1'b0;
      busOut    <= '0;
    end else begin
      leftRdEn  <= strb.rdLeft;
      rightRdEn <= strb.rdRight;
      rdIsData  <= (strb.rdLeft | strb.rdRight) & strb.isData;
      busDrive  <= strb.rdLeft | strb.rdRight;
      busOut    <= strb.rdLeft ? leftRdData : rightRdData;
    end
  end

  // R10
  wr_pulse_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftWrPulse | rightWrPulse) |=> !(leftWrPulse | rightWrPulse));

  // R10
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftWrPulse | rightWrPulse) |-> $stable(wrData));

  // R9
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (leftRdEn | rightRdEn));

  // R7
  left_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive & leftRdEn) |-> (busOut == $past(leftRdData)));
endmodule

// File: rtl/duo_host_bus.sv
module duo_host_bus
  import hbb_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         strapPar,
  input  logic         strapMode,
  input  logic         busE,
  input  logic         busRw,
  input  logic         busRs,
  input  logic         csLeftHi,
  input  logic         csLeftLoN,
  input  logic         csRightHi,
  input  logic         csRightLoN,
  inout  wire  [W-1:0] dataBus,
  input  logic [W-1:0] leftRdData,
  input  logic [W-1:0] rightRdData,
  output logic         leftWrPulse,
  output logic         rightWrPulse,
  output logic [W-1:0] wrData,
  output logic         wrIsData,
  output logic         leftRdEn,
  output logic         rightRdEn,
  output logic         rdIsData
);
  hbbStrobe_t   strb;
  logic         busDrive;
  logic [W-1:0] busOut;

  hbb_ctrl #(.STAGES(STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .strapPar(strapPar), .strapMode(strapMode),
    .busE(busE), .busRw(busRw), .busRs(busRs),
    .csLeftHi(csLeftHi), .csLeftLoN(csLeftLoN),
    .csRightHi(csRightHi), .csRightLoN(csRightLoN),
    .strb(strb)
  );

  hbb_datapath #(.W(W), .STAGES(STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(dataBus),
    .leftRdData(leftRdData), .rightRdData(rightRdData),
    .busDrive(busDrive), .busOut(busOut),
    .leftWrPulse(leftWrPulse), .rightWrPulse(rightWrPulse),
    .wrData(wrData), .wrIsData(wrIsData),
    .leftRdEn(leftRdEn), .rightRdEn(rightRdEn), .rdIsData(rdIsData)
  );

  assign dataBus = busDrive ? busOut : {W{1'bz}};
endmodule

// File: tb/duo_host_bus_tb.sv
`timescale 1ns/1ps
module duo_host_bus_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapPar = 1'b1, strapMode = 1'b1;
  logic busE = 1'b0, busRw = 1'b1, busRs = 1'b0;
  logic csLeftHi = 1'b0, csLeftLoN = 1'b1, csRightHi = 1'b0, csRightLoN = 1'b1;
  logic tbDrv = 1'b0;
  logic [7:0] tbData = 8'h00;
  logic [7:0] leftRdData = 8'h00, rightRdData = 8'h00;
  wire  [7:0] dataBus;
  logic leftWrPulse, rightWrPulse, wrIsData, leftRdEn, rightRdEn, rdIsData;
  logic [7:0] wrData;

  int testCount = 0, failCount = 0;
  int cntL = 0, cntR = 0;
  logic [7:0] seenL = 8'h00, seenR = 8'h00;
  logic seenRsL = 1'b0;
  logic done = 1'b0;

  assign dataBus = tbDrv ? tbData : 8'hzz;

  always #2 clk = ~clk;

  duo_host_bus dut_i (
    .clk(clk), .rstN(rstN), .strapPar(strapPar), .strapMode(strapMode),
    .busE(busE), .busRw(busRw), .busRs(busRs),
    .csLeftHi(csLeftHi), .csLeftLoN(csLeftLoN),
    .csRightHi(csRightHi), .csRightLoN(csRightLoN),
    .dataBus(dataBus), .leftRdData(leftRdData), .rightRdData(rightRdData),
    .leftWrPulse(leftWrPulse), .rightWrPulse(rightWrPulse),
    .wrData(wrData), .wrIsData(wrIsData),
    .leftRdEn(leftRdEn), .rightRdEn(rightRdEn), .rdIsData(rdIsData)
  );

  always @(posedge clk) begin
    if (leftWrPulse)  begin cntL++; seenL = wrData; seenRsL = wrIsData; end
    if (rightWrPulse) begin cntR++; seenR = wrData; end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSel(input logic [3:0] cs);
    {csLeftHi, csLeftLoN, csRightHi, csRightLoN} = cs;
  endtask

  task automatic setProto(input logic par, input logic m);
    setSel(4'b0101);
    idle(2);
    strapPar = par; strapMode = m;
    busE = m ? 1'b0 : 1'b1;
    busRw = 1'b1;
    idle(6);
  endtask

  // one write, pulses counted per half
  task automatic doWrite(input logic m, input logic [3:0] cs, input logic rs, input logic [7:0] b);
    cntL = 0; cntR = 0;
    setSel(cs); busRs = rs; tbData = b; tbDrv = 1'b1;
    if (m) begin
      busRw = 1'b0; idle(4); busE = 1'b1; idle(4); busE = 1'b0; idle(4); busRw = 1'b1;
    end else begin
      busRw = 1'b0; idle(4); busRw = 1'b1;
    end
    idle(6);
    tbDrv = 1'b0;
    idle(1);
  endtask

  task automatic readOn(input logic m, input logic [3:0] cs, input logic rs);
    setSel(cs); busRs = rs; tbDrv = 1'b0;
    if (m) begin busRw = 1'b1; busE = 1'b1; end
    else busE = 1'b0;
    idle(6);
  endtask

  task automatic readOff(input logic m);
    busE = m ? 1'b0 : 1'b1;
    idle(6);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1", "wrPulse in reset", {leftWrPulse, rightWrPulse}, 0);
    check("R1", "dataBus in reset", (dataBus === 8'hzz), 1);
    rstN = 1'b1;
    idle(6);
    check("R1", "outputs after reset", {leftWrPulse, rightWrPulse, leftRdEn, rightRdEn, rdIsData, wrIsData}, 0);
    check("R1", "wrData after reset", wrData, 0);
    check("R1", "dataBus after reset", (dataBus === 8'hzz), 1);

    for (int m = 1; m >= 0; m--) begin
      setProto(1'b1, m[0]);
      for (int c = 0; c < 16; c++) begin
        for (int rs = 0; rs < 2; rs++) begin
          logic [3:0] cs;
          logic selL, selR;
          logic [7:0] b;
          string rw, rr;
          cs = c[3:0];
          selL = cs[3] & ~cs[2];
          selR = cs[1] & ~cs[0];
          b = 8'(c * 16 + rs * 7 + m * 3 + 1);
          rw = m ? "R2/R6/R7" : "R4/R6/R7";
          rr = m ? "R3/R6/R7" : "R5/R6/R7";
          doWrite(m[0], cs, rs[0], b);
          check(rw, "left pulses", cntL, {31'd0, selL});
          check(rw, "right pulses", cntR, {31'd0, selR});
          if (selL) begin
            check(rw, "left data", seenL, b);
            check(rw, "rs flag", seenRsL, rs[0]);
          end
          if (selR) check(rw, "right data", seenR, b);
          leftRdData = 8'hA0 ^ 8'(c); rightRdData = 8'h50 ^ 8'(c);
          readOn(m[0], cs, rs[0]);
          check(rr, "read enables", {leftRdEn, rightRdEn}, {selL, selR});
          if (selL | selR) begin
            check(rr, "dataBus", dataBus, selL ? (8'hA0 ^ 8'(c)) : (8'h50 ^ 8'(c)));
            check(rr, "rdIsData", rdIsData, rs[0]);
          end else
            check("R9", "bus floats unselected", (dataBus === 8'hzz), 1);
          readOff(m[0]);
          check("R9", "bus floats after read", (dataBus === 8'hzz), 1);
          check("R10", "no stray pulse", {leftWrPulse, rightWrPulse}, 0);
        end
      end
    end

    // R8 parallel bus off
    for (int m = 0; m < 2; m++) begin
      setProto(1'b0, m[0]);
      for (int c = 0; c < 16; c++) begin
        doWrite(m[0], c[3:0], 1'b1, 8'h3C);
        check("R8", "no pulses when off", cntL + cntR, 0);
        readOn(m[0], c[3:0], 1'b1);
        check("R8", "no read enables", {leftRdEn, rightRdEn}, 0);
        check("R8", "bus floats when off", (dataBus === 8'hzz), 1);
        readOff(m[0]);
      end
    end

    // R10 wrData holds across a non-write access
    setProto(1'b1, 1'b1);
    doWrite(1'b1, 4'b1001, 1'b0, 8'h5A);
    readOn(1'b1, 4'b1001, 1'b0);
    readOff(1'b1);
    check("R10", "wrData held", wrData, 8'h5A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule